// File: doc/BRIEF.md
# Packet Acknowledge Decision Unit

This block sits on the receive side of a network port. It decides whether an incoming packet is acknowledged. It watches a stream of already-decoded transaction events, framed by start-of-packet and end-of-packet strobes. For each transaction it returns one verdict: execute, discard or trap to the error buffer. Once per packet it may also raise a single ACK or NACK strobe. The ACK can come from any transaction in the middle of a packet, when that transaction requests an immediate acknowledge. Conditional transactions combine as a sequential AND: the first false test rejects the rest of the packet. A failure that happens after the ACK has gone out cannot become a NACK. In that case the failing transaction and everything after it are diverted to the error buffer, and an exception pulse is raised.

The block holds a context filter register with an enable bit. It is loaded through a one-cycle write strobe. When enabled, any transaction whose context equals the stored value is treated as a failure. Every result is registered and appears exactly one cycle after the input that caused it.

The controller has five states:
- `ST_IDLE`: outside a packet.
- `ST_OPEN`: inside a packet, no response sent yet.
- `ST_ACKED`: ACK sent, transactions still executing.
- `ST_REJECT`: NACK sent, transactions discarded.
- `ST_TRAP`: failure after ACK, transactions trapped.

The transitions are:
- start: any state to `ST_OPEN` on start-of-packet.
- finish: any state to `ST_IDLE` on end-of-packet.
- acknowledge: `ST_OPEN` to `ST_ACKED` on a good transaction with the acknowledge request.
- reject: `ST_OPEN` to `ST_REJECT` on a failing transaction.
- divert: `ST_ACKED` to `ST_TRAP` on a failing transaction.

If several strobes arrive in one cycle, start-of-packet wins over end-of-packet, and end-of-packet wins over a transaction.

Top module: `pkt_ack_unit`

## Requirements
- R1: After reset all outputs are low, the controller is outside any packet and the context filter is disabled.
- R2: Each transaction received inside a packet produces exactly one of execute, discard or trap, one cycle later.
- R3: While no response has been sent, a non-failing transaction with the acknowledge request executes and raises ACK in the same output cycle.
- R4: While no response has been sent, a transaction that arrives with input busy or with a CRC error raises NACK and is discarded. Every later transaction in that packet is discarded.
- R5: A conditional transaction whose test is false fails like a CRC error. A true test executes and processing continues, so several conditionals form a sequential AND.
- R6: At most one ACK or NACK is produced per packet. A later acknowledge request after the response has been sent raises nothing more.
- R7: After an ACK, a failing transaction and every later transaction in the packet are trapped instead of executed.
- R8: The failing transaction after an ACK also raises a one-cycle NACK-after-ACK exception pulse, and no NACK.
- R9: With the filter enabled, a transaction whose context equals the stored filter context counts as a failure.
- R10: With the filter disabled, no context is filtered. A write strobe loads both the enable bit and the context.
- R11: End-of-packet with no ACK or NACK yet sent raises NACK and a protocol-error pulse. End-of-packet after a response raises nothing.
- R12: Transactions seen outside a packet, before start-of-packet, produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_sop | input | 1 | Start-of-packet strobe |
| pkt_eop | input | 1 | End-of-packet strobe |
| txn_valid | input | 1 | One decoded transaction this cycle |
| txn_ack_now | input | 1 | Transaction requests immediate acknowledge |
| txn_crc_ok | input | 1 | Transaction CRC was valid |
| txn_is_cond | input | 1 | Transaction is a network conditional |
| txn_cond_true | input | 1 | Result of the conditional test |
| txn_ctx | input | CTX_W | Context carried by the transaction |
| in_busy | input | 1 | Input side cannot accept the transaction |
| flt_wr | input | 1 | Write strobe for the filter register |
| flt_wr_en | input | 1 | Filter enable value to write |
| flt_wr_ctx | input | CTX_W | Filter context value to write |
| ack_o | output | 1 | ACK strobe |
| nack_o | output | 1 | NACK strobe |
| txn_exec_o | output | 1 | Transaction is executed |
| txn_discard_o | output | 1 | Transaction is discarded |
| txn_trap_o | output | 1 | Transaction is diverted to the error buffer |
| nack_after_ack_o | output | 1 | NACK-after-ACK exception pulse |
| proto_err_o | output | 1 | End-of-packet arrived without a response |

## Verification
Every result of this block comes from one output register. The verdicts, ACK, NACK, the exception and the protocol error are all due in the cycle after the input edge that sampled their cause. A filter write becomes visible to the next transaction. The driver applies one event per cycle on the falling edge and pushes the expected output vector for that event into a queue. A monitor waits one nanosecond after each rising edge, pops one entry and compares it, so every comparison lands in the single cycle where the result is valid.

// File: rtl/pau_pkg.sv
package pau_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_ACKED,
        ST_REJECT,
        ST_TRAP
    } pau_state_e;

    typedef struct packed {
        logic ack;
        logic nack;
        logic exec;
        logic discard;
        logic trap;
        logic exc;
        logic perr;
    } pau_out_t;

endpackage

// File: rtl/pau_ctx_filter.sv
module pau_ctx_filter #(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [CTX_W-1:0] ctx,
    output logic             hit
);
    logic             en_q;
    logic [CTX_W-1:0] ctx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ctx_q <= '0;
        end else if (wr) begin
            en_q  <= wr_en;
            ctx_q <= wr_ctx;
        end
    end

    assign hit = en_q && (ctx == ctx_q);
endmodule

// File: rtl/pau_txn_judge.sv
module pau_txn_judge (
    input  logic crc_ok,
    input  logic busy,
    input  logic is_cond,
    input  logic cond_true,
    input  logic filt_hit,
    output logic fail
);
    // A transaction fails on busy input, bad CRC, false conditional or a filtered context
    always_comb begin
        fail = busy || !crc_ok || filt_hit || (is_cond && !cond_true);
    end
endmodule

// File: rtl/pkt_ack_unit.sv
module pkt_ack_unit
    import pau_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_sop,
    input  logic             pkt_eop,
    input  logic             txn_valid,
    input  logic             txn_ack_now,
    input  logic             txn_crc_ok,
    input  logic             txn_is_cond,
    input  logic             txn_cond_true,
    input  logic [CTX_W-1:0] txn_ctx,
    input  logic             in_busy,
    input  logic             flt_wr,
    input  logic             flt_wr_en,
    input  logic [CTX_W-1:0] flt_wr_ctx,
    output logic             ack_o,
    output logic             nack_o,
    output logic             txn_exec_o,
    output logic             txn_discard_o,
    output logic             txn_trap_o,
    output logic             nack_after_ack_o,
    output logic             proto_err_o
);
    pau_state_e state_q, state_d;
    pau_out_t   out_d, out_q;
    logic       filt_hit;
    logic       fail;

    pau_ctx_filter #(.CTX_W(CTX_W)) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (flt_wr),
        .wr_en  (flt_wr_en),
        .wr_ctx (flt_wr_ctx),
        .ctx    (txn_ctx),
        .hit    (filt_hit)
    );

    pau_txn_judge u_judge (
        .crc_ok    (txn_crc_ok),
        .busy      (in_busy),
        .is_cond   (txn_is_cond),
        .cond_true (txn_cond_true),
        .filt_hit  (filt_hit),
        .fail      (fail)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (pkt_sop) begin
            state_d = ST_OPEN;
        end else if (pkt_eop) begin
            state_d = ST_IDLE;
        end else if (txn_valid) begin
            unique case (state_q)
                ST_OPEN: begin
                    if (fail)             state_d = ST_REJECT;
                    else if (txn_ack_now) state_d = ST_ACKED;
                end
                ST_ACKED: begin
                    if (fail) state_d = ST_TRAP;
                end
                default: state_d = state_q;
            endcase
        end
    end

    // Outputs
    always_comb begin
        out_d = '0;
        if (pkt_sop) begin
            out_d = '0;
        end else if (pkt_eop) begin
            if (state_q == ST_OPEN) begin
                out_d.nack = 1'b1;
                out_d.perr = 1'b1;
            end
        end else if (txn_valid) begin
            unique case (state_q)
                ST_IDLE: out_d = '0;
                ST_OPEN: begin
                    if (fail) begin
                        out_d.nack    = 1'b1;
                        out_d.discard = 1'b1;
                    end else begin
                        out_d.exec = 1'b1;
                        out_d.ack  = txn_ack_now;
                    end
                end
                ST_ACKED: begin
                    if (fail) begin
                        out_d.trap = 1'b1;
                        out_d.exc  = 1'b1;
                    end else begin
                        out_d.exec = 1'b1;
                    end
                end
                ST_REJECT: out_d.discard = 1'b1;
                ST_TRAP:   out_d.trap    = 1'b1;
                default:   out_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ack_o            = out_q.ack;
    assign nack_o           = out_q.nack;
    assign txn_exec_o       = out_q.exec;
    assign txn_discard_o    = out_q.discard;
    assign txn_trap_o       = out_q.trap;
    assign nack_after_ack_o = out_q.exc;
    assign proto_err_o      = out_q.perr;
endmodule

// File: rtl/pau_ack_checker.sv
module pau_ack_checker (
    input logic clk,
    input logic rst_n,
    input logic pkt_sop,
    input logic pkt_eop,
    input logic txn_valid,
    input logic txn_ack_now,
    input logic txn_crc_ok,
    input logic ack_o,
    input logic nack_o,
    input logic txn_exec_o,
    input logic txn_discard_o,
    input logic txn_trap_o,
    input logic nack_after_ack_o,
    input logic proto_err_o
);
    logic responded_q;

    always_ff @(posedge clk) begin
        if (!rst_n)               responded_q <= 1'b0;
        else if (pkt_sop)         responded_q <= 1'b0;
        else if (ack_o || nack_o) responded_q <= 1'b1;
    end

    // R6: never a second response within a packet
    a_r6_single_response: assert property (@(posedge clk) disable iff (!rst_n)
        !(responded_q && (ack_o || nack_o)));

    // R2: at most one verdict per cycle
    a_r2_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({txn_exec_o, txn_discard_o, txn_trap_o}));

    // R3: an ACK needs a good transaction with the acknowledge request one cycle earlier
    a_r3_ack_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(txn_valid && txn_ack_now && txn_crc_ok && !pkt_sop && !pkt_eop));

    // R8: the exception accompanies a trapped transaction and never a NACK
    a_r8_exc_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        nack_after_ack_o |-> (txn_trap_o && !nack_o));

    // R11: protocol error only with NACK, caused by end-of-packet
    a_r11_perr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |-> (nack_o && $past(pkt_eop)));
endmodule

bind pkt_ack_unit pau_ack_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .pkt_sop          (pkt_sop),
    .pkt_eop          (pkt_eop),
    .txn_valid        (txn_valid),
    .txn_ack_now      (txn_ack_now),
    .txn_crc_ok       (txn_crc_ok),
    .ack_o            (ack_o),
    .nack_o           (nack_o),
    .txn_exec_o       (txn_exec_o),
    .txn_discard_o    (txn_discard_o),
    .txn_trap_o       (txn_trap_o),
    .nack_after_ack_o (nack_after_ack_o),
    .proto_err_o      (proto_err_o)
);

// File: tb/pkt_ack_unit_test.sv
`timescale 1ns/1ps
module pkt_ack_unit_test;
    localparam int CTX_W = 8;
    localparam logic [6:0] O_ACK  = 7'b1000000;
    localparam logic [6:0] O_NACK = 7'b0100000;
    localparam logic [6:0] O_EX   = 7'b0010000;
    localparam logic [6:0] O_DIS  = 7'b0001000;
    localparam logic [6:0] O_TR   = 7'b0000100;
    localparam logic [6:0] O_EXC  = 7'b0000010;
    localparam logic [6:0] O_PE   = 7'b0000001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pkt_sop = 0, pkt_eop = 0, txn_valid = 0, txn_ack_now = 0;
    logic txn_crc_ok = 0, txn_is_cond = 0, txn_cond_true = 0, in_busy = 0;
    logic [CTX_W-1:0] txn_ctx = '0;
    logic flt_wr = 0, flt_wr_en = 0;
    logic [CTX_W-1:0] flt_wr_ctx = '0;
    logic ack_o, nack_o, txn_exec_o, txn_discard_o, txn_trap_o, nack_after_ack_o, proto_err_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [6:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    pkt_ack_unit #(.CTX_W(CTX_W)) uut (
        .clk(clk), .rst_n(rst_n), .pkt_sop(pkt_sop), .pkt_eop(pkt_eop),
        .txn_valid(txn_valid), .txn_ack_now(txn_ack_now), .txn_crc_ok(txn_crc_ok),
        .txn_is_cond(txn_is_cond), .txn_cond_true(txn_cond_true), .txn_ctx(txn_ctx),
        .in_busy(in_busy), .flt_wr(flt_wr), .flt_wr_en(flt_wr_en), .flt_wr_ctx(flt_wr_ctx),
        .ack_o(ack_o), .nack_o(nack_o), .txn_exec_o(txn_exec_o),
        .txn_discard_o(txn_discard_o), .txn_trap_o(txn_trap_o),
        .nack_after_ack_o(nack_after_ack_o), .proto_err_o(proto_err_o)
    );

    function automatic logic [6:0] outs();
        return {ack_o, nack_o, txn_exec_o, txn_discard_o, txn_trap_o, nack_after_ack_o, proto_err_o};
    endfunction

    task automatic compare(input logic [6:0] exp, input string tag);
        checks++;
        if (outs() !== exp) begin
            failures++;
            $display("FAIL %s: outputs actual=%b expected=%b", tag, outs(), exp);
        end
    endtask

    // Monitor: results are due one cycle after the driving edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic drive(input logic sop, input logic eop, input logic v, input logic an,
                         input logic crc, input logic ic, input logic ct, input logic busy,
                         input logic [CTX_W-1:0] ctx, input logic [6:0] exp, input string tag);
        @(negedge clk);
        pkt_sop = sop; pkt_eop = eop; txn_valid = v; txn_ack_now = an;
        txn_crc_ok = crc; txn_is_cond = ic; txn_cond_true = ct; in_busy = busy;
        txn_ctx = ctx; flt_wr = 1'b0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic sop(input string tag);
        drive(1, 0, 0, 0, 0, 0, 0, 0, '0, 7'b0, tag);
    endtask
    task automatic eop(input logic [6:0] exp, input string tag);
        drive(0, 1, 0, 0, 0, 0, 0, 0, '0, exp, tag);
    endtask
    // plain transaction: ack request, crc ok, context
    task automatic txn(input logic an, input logic crc, input logic [CTX_W-1:0] ctx,
                       input logic [6:0] exp, input string tag);
        drive(0, 0, 1, an, crc, 0, 0, 0, ctx, exp, tag);
    endtask
    task automatic ctxn(input logic an, input logic ct, input logic [6:0] exp, input string tag);
        drive(0, 0, 1, an, 1, 1, ct, 0, '0, exp, tag);
    endtask
    task automatic fwrite(input logic en, input logic [CTX_W-1:0] c);
        @(negedge clk);
        pkt_sop = 0; pkt_eop = 0; txn_valid = 0; in_busy = 0;
        flt_wr = 1'b1; flt_wr_en = en; flt_wr_ctx = c;
        exp_q.push_back(7'b0);
        tag_q.push_back("R10 write cycle");
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(7'b0, "R1 outputs during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(7'b0, "R1 outputs after reset");

        // R12: stray transaction before start-of-packet
        txn(1, 1, 8'd1, 7'b0, "R12 route bytes before SOP ignored");
        // R1: filter disabled after reset, context 0 not filtered
        sop("R2 sop");
        txn(0, 1, 8'd0, O_EX, "R2 plain txn executes");
        txn(1, 1, 8'd0, O_EX | O_ACK, "R3 ack-now txn acks");
        txn(0, 1, 8'd0, O_EX, "R2 txn after ack executes");
        txn(1, 1, 8'd0, O_EX, "R6 second ack-now raises nothing");
        eop(7'b0, "R11 eop after ack quiet");
        txn(0, 1, 8'd0, 7'b0, "R12 txn after eop ignored");

        // R4: CRC error before ack
        sop("R4 sop");
        txn(0, 0, 8'd0, O_NACK | O_DIS, "R4 crc error nacks");
        txn(1, 1, 8'd0, O_DIS, "R6 later ack-now discarded, no ack");
        eop(7'b0, "R6 eop after nack quiet");

        // R4: busy
        sop("R4 sop busy");
        drive(0, 0, 1, 1, 1, 0, 0, 1, '0, O_NACK | O_DIS, "R4 busy nacks");
        eop(7'b0, "R4 eop");

        // R5: conditionals true then ack
        sop("R5 sop");
        ctxn(0, 1, O_EX, "R5 true cond executes");
        ctxn(1, 1, O_EX | O_ACK, "R5 second true cond acks");
        eop(7'b0, "R5 eop");
        // R5: false cond
        sop("R5 sop false");
        ctxn(0, 1, O_EX, "R5 true cond executes");
        ctxn(0, 0, O_NACK | O_DIS, "R5 false cond nacks");
        txn(1, 1, 8'd0, O_DIS, "R5 rest discarded");
        eop(7'b0, "R5 eop");

        // R7/R8: failure after ack
        sop("R7 sop");
        txn(1, 1, 8'd0, O_EX | O_ACK, "R3 ack");
        txn(0, 0, 8'd0, O_TR | O_EXC, "R8 crc error after ack traps with exception");
        txn(0, 1, 8'd0, O_TR, "R7 remaining trapped");
        eop(7'b0, "R7 eop");
        sop("R7 sop cond");
        txn(1, 1, 8'd0, O_EX | O_ACK, "R3 ack");
        ctxn(0, 0, O_TR | O_EXC, "R8 false cond after ack traps");
        eop(7'b0, "R7 eop");

        // R9/R10: context filter
        fwrite(1, 8'd5);
        sop("R9 sop");
        txn(1, 1, 8'd5, O_NACK | O_DIS, "R9 filtered context nacks");
        eop(7'b0, "R9 eop");
        sop("R9 sop other");
        txn(1, 1, 8'd6, O_EX | O_ACK, "R9 other context passes");
        txn(0, 1, 8'd5, O_TR | O_EXC, "R9 filtered after ack traps");
        eop(7'b0, "R9 eop");
        fwrite(0, 8'd5);
        sop("R10 sop");
        txn(1, 1, 8'd5, O_EX | O_ACK, "R10 filter disabled passes");
        eop(7'b0, "R10 eop");

        // R11: eop without response
        sop("R11 sop");
        txn(0, 1, 8'd0, O_EX, "R11 txn without ack request");
        eop(O_NACK | O_PE, "R11 eop nacks with protocol error");
        drive(0, 0, 0, 0, 0, 0, 0, 0, '0, 7'b0, "R11 idle after eop");
        drive(0, 0, 0, 0, 0, 0, 0, 0, '0, 7'b0, "R1 idle");

        @(posedge clk);
        #2;
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule